// File: doc/BRIEF.md
# Column-Parallel Single-Slope Converter Digital Back End

This block is the digital side of a bank of single-slope analog-to-digital converters, one per column. A start pulse clears the shared Gray-code counter and every per-channel capture register. The counter then advances once per clock while an external ramp rises. Each channel has a comparator output (`trip`). On the first cycle that a channel's trip is high, that channel keeps the counter's current Gray value. When the count reaches the top of the selected resolution, the conversion ends. Channels that never tripped receive the full-scale code.

After the conversion, a scanner sends the captured words out one at a time. A word appears every second clock, so the data rate is half the counter rate. The scan can run from channel 0 upward or from the last channel downward. In pair mode, analog averaging upstream has merged each adjacent pair onto its even channel, so only the even channel of each pair is sent and the frame holds half as many words. Resolution, direction and pair mode are sampled only on the start pulse that the block accepts.

A sequencer has three states. SEQ_IDLE goes to SEQ_CONV on an accepted start. SEQ_CONV goes to SEQ_READ on the last count. SEQ_READ goes back to SEQ_IDLE when the scanner finishes. The scanner also has three states. SC_IDLE goes to SC_EMIT when the conversion ends. SC_EMIT always goes to SC_GAP. SC_GAP goes back to SC_EMIT while words remain, and to SC_IDLE after the last word.

Top module: `ssadc_backend`

## Requirements
- R1: The counter output is Gray code. It is zero in the first conversion cycle after an accepted start, and each following conversion cycle changes exactly one bit.
- R2: The effective resolution N is `cfg_res` clamped to the range 9..14. A conversion lasts 2^N cycles, with counts 0 to 2^N-1. `conv_done` is high only in the cycle that holds count 2^N-1.
- R3: Suppose a channel's trip is first high in the cycle holding count k. That channel's word is then the Gray code of k, which is k XOR (k>>1).
- R4: After a channel has captured a value, later trip activity in the same conversion leaves its word unchanged. Trip activity while idle has no effect.
- R5: A channel whose trip is never high during the conversion gets the Gray code of 2^N-1, which has only bit N-1 set.
- R6: Output words are raw Gray values on bits N-1..0 of `out_data`. All bits from N upward are zero.
- R7: With `cfg_dir`=0 the words leave in channel order 0, 1, ... NCH-1. With `cfg_dir`=1 they leave in order NCH-1 down to 0.
- R8: With `cfg_avg`=1 the frame holds NCH/2 words. Each word is the even channel 2p of pair p. The pairs are sent in ascending order with `cfg_dir`=0 and descending order with `cfg_dir`=1.
- R9: Each word is marked by `out_valid` high for exactly one cycle, and `out_valid` is never high in two consecutive cycles. `out_sof` is high only together with the first word of a frame.
- R10: A start while `busy` is high is ignored. Changes to the configuration inputs after an accepted start do not affect that frame.
- R11: After reset, `busy`, `conv_done`, `out_valid` and `out_sof` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion start pulse |
| cfg_res | input | 4 | Requested resolution, clamped to 9..14 |
| cfg_dir | input | 1 | Scan direction, 0 = ascending |
| cfg_avg | input | 1 | Pair mode enable |
| trip | input | NCH | Per-channel comparator outputs |
| busy | output | 1 | High from accepted start until the last word is sent |
| conv_done | output | 1 | High in the final count cycle |
| out_valid | output | 1 | One-cycle strobe marking a word |
| out_sof | output | 1 | Frame sync, high with the first word |
| out_data | output | DW | Gray-coded word |

## Verification
The assertions assume that `trip` and the configuration inputs change only away from the active clock edge. The comparator outputs are taken to be already synchronous to `clk`. They also assume that `start` is a single-cycle pulse. The bench drives every input on the falling edge. It holds each trip level from its target count onward, as a rising ramp would. It adds deliberate one-cycle drops on some channels, trip activity while idle, configuration changes during conversion, and a start pulse during readout. These disturbances test the points where the block must ignore its inputs.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;

    localparam int MIN_RES = 9;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CONV = 2'd1,
        SEQ_READ = 2'd2
    } seq_st_e;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_EMIT = 2'd1,
        SC_GAP  = 2'd2
    } scan_st_e;

endpackage

// File: rtl/ssadc_gray_counter.sv
module ssadc_gray_counter #(
    parameter int DW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic [DW-1:0] limit,
    output logic [DW-1:0] gray,
    output logic          at_limit
);

    logic [DW-1:0] bin_q;
    logic [DW-1:0] bin_d;

    assign at_limit = (bin_q == limit);

    always_comb begin
        bin_d = bin_q;
        if (clear) begin
            bin_d = '0;
        end else if (run && !at_limit) begin
            bin_d = bin_q + DW'(1);
        end
    end

    // Gray value is registered so the shared bus toggles one bit per step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q <= '0;
            gray  <= '0;
        end else begin
            bin_q <= bin_d;
            gray  <= bin_d ^ (bin_d >> 1);
        end
    end

endmodule

// File: rtl/ssadc_chan_bank.sv
module ssadc_chan_bank #(
    parameter int NCH = 128,
    parameter int DW  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    sample_en,
    input  logic                    final_cyc,
    input  logic [DW-1:0]           code,
    input  logic [NCH-1:0]          trip,
    output logic [NCH-1:0][DW-1:0]  words
);

    logic [NCH-1:0] taken_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        // First trip wins; the final count fills any channel still open
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                taken_q[ch] <= 1'b0;
                words[ch]   <= '0;
            end else if (clear) begin
                taken_q[ch] <= 1'b0;
                words[ch]   <= '0;
            end else if (sample_en && !taken_q[ch] && (trip[ch] || final_cyc)) begin
                taken_q[ch] <= 1'b1;
                words[ch]   <= code;
            end
        end
    end

endmodule

// File: rtl/ssadc_scanner.sv
module ssadc_scanner
    import ssadc_pkg::*;
#(
    parameter int NCH = 128,
    parameter int DW  = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    go,
    input  logic                    dir_down,
    input  logic                    pair_mode,
    input  logic [NCH-1:0][DW-1:0]  words,
    output logic                    word_valid,
    output logic                    word_sof,
    output logic [DW-1:0]           word_data,
    output logic                    scan_done
);

    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CNT_W = IDX_W + 1;

    scan_st_e          st_q, st_d;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  left_q;
    logic              first_q;
    logic              dir_q;
    logic              pair_q;
    logic [IDX_W-1:0]  step;

    assign step = pair_q ? IDX_W'(2) : IDX_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SC_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SC_IDLE: if (go) st_d = SC_EMIT;
            SC_EMIT: st_d = SC_GAP;
            SC_GAP:  st_d = (left_q == '0) ? SC_IDLE : SC_EMIT;
            default: st_d = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            left_q  <= '0;
            first_q <= 1'b0;
            dir_q   <= 1'b0;
            pair_q  <= 1'b0;
        end else begin
            unique case (st_q)
                SC_IDLE: begin
                    if (go) begin
                        dir_q   <= dir_down;
                        pair_q  <= pair_mode;
                        first_q <= 1'b1;
                        left_q  <= pair_mode ? CNT_W'(NCH / 2) : CNT_W'(NCH);
                        if (!dir_down) begin
                            idx_q <= '0;
                        end else if (pair_mode) begin
                            idx_q <= IDX_W'(NCH - 2);
                        end else begin
                            idx_q <= IDX_W'(NCH - 1);
                        end
                    end
                end
                SC_EMIT: begin
                    first_q <= 1'b0;
                    left_q  <= left_q - CNT_W'(1);
                end
                SC_GAP: begin
                    if (left_q != '0) begin
                        idx_q <= dir_q ? (idx_q - step) : (idx_q + step);
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        word_valid = (st_q == SC_EMIT);
        word_sof   = (st_q == SC_EMIT) && first_q;
        word_data  = words[idx_q];
        scan_done  = (st_q == SC_GAP) && (left_q == '0);
    end

endmodule

// File: rtl/ssadc_backend.sv
module ssadc_backend
    import ssadc_pkg::*;
#(
    parameter int NCH   = 128,
    parameter int DW    = 14,
    parameter int RES_W = $clog2(DW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RES_W-1:0] cfg_res,
    input  logic             cfg_dir,
    input  logic             cfg_avg,
    input  logic [NCH-1:0]   trip,
    output logic             busy,
    output logic             conv_done,
    output logic             out_valid,
    output logic             out_sof,
    output logic [DW-1:0]    out_data
);

    seq_st_e               st_q, st_d;
    logic [RES_W-1:0]      res_q;
    logic [RES_W-1:0]      res_clamped;
    logic                  dir_q;
    logic                  avg_q;
    logic                  accept;
    logic [DW-1:0]         limit;
    logic [DW-1:0]         cnt_gray;
    logic                  at_limit;
    logic                  last_cnt;
    logic                  scan_done;
    logic [NCH-1:0][DW-1:0] words;

    always_comb begin
        if (cfg_res < RES_W'(MIN_RES)) begin
            res_clamped = RES_W'(MIN_RES);
        end else if (cfg_res > RES_W'(DW)) begin
            res_clamped = RES_W'(DW);
        end else begin
            res_clamped = cfg_res;
        end
    end

    assign accept   = start && (st_q == SEQ_IDLE);
    assign limit    = (DW'(1) << res_q) - DW'(1);
    assign last_cnt = (st_q == SEQ_CONV) && at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SEQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SEQ_IDLE: if (accept)    st_d = SEQ_CONV;
            SEQ_CONV: if (at_limit)  st_d = SEQ_READ;
            SEQ_READ: if (scan_done) st_d = SEQ_IDLE;
            default:                 st_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= RES_W'(MIN_RES);
            dir_q <= 1'b0;
            avg_q <= 1'b0;
        end else if (accept) begin
            res_q <= res_clamped;
            dir_q <= cfg_dir;
            avg_q <= cfg_avg;
        end
    end

    always_comb begin
        busy      = (st_q != SEQ_IDLE);
        conv_done = last_cnt;
    end

    ssadc_gray_counter #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .run      (st_q == SEQ_CONV),
        .limit    (limit),
        .gray     (cnt_gray),
        .at_limit (at_limit)
    );

    ssadc_chan_bank #(.NCH(NCH), .DW(DW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sample_en (st_q == SEQ_CONV),
        .final_cyc (last_cnt),
        .code      (cnt_gray),
        .trip      (trip),
        .words     (words)
    );

    ssadc_scanner #(.NCH(NCH), .DW(DW)) u_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (last_cnt),
        .dir_down   (dir_q),
        .pair_mode  (avg_q),
        .words      (words),
        .word_valid (out_valid),
        .word_sof   (out_sof),
        .word_data  (out_data),
        .scan_done  (scan_done)
    );

endmodule

// File: rtl/ssadc_backend_chk.sv
module ssadc_backend_chk
    import ssadc_pkg::*;
#(
    parameter int NCH   = 128,
    parameter int DW    = 14,
    parameter int RES_W = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input seq_st_e                 st_q,
    input logic [DW-1:0]           cnt_gray,
    input logic [RES_W-1:0]        res_q,
    input logic [NCH-1:0][DW-1:0]  words,
    input logic                    busy,
    input logic                    conv_done,
    input logic                    out_valid,
    input logic                    out_sof,
    input logic [DW-1:0]           out_data
);

    logic [DW-1:0] hi_mask;
    assign hi_mask = ~((DW'(1) << res_q) - DW'(1));

    assert_gray_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_CONV && $past(st_q) == SEQ_CONV)
            |-> $countones(cnt_gray ^ $past(cnt_gray)) == 1);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> !conv_done);

    assert_res_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (res_q >= RES_W'(MIN_RES) && res_q <= RES_W'(DW)));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SEQ_READ && $past(st_q) == SEQ_READ) |-> $stable(words));

    assert_hi_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data & hi_mask) == '0));

    assert_strobe_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_sof_with_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(res_q));

endmodule

bind ssadc_backend ssadc_backend_chk #(.NCH(NCH), .DW(DW), .RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_q      (st_q),
    .cnt_gray  (cnt_gray),
    .res_q     (res_q),
    .words     (words),
    .busy      (busy),
    .conv_done (conv_done),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_data  (out_data)
);

// File: tb/ssadc_backend_test.sv
module ssadc_backend_test;

    localparam int NCH = 128;
    localparam int DW  = 14;

    typedef struct {
        logic [DW-1:0] d;
        logic          sof;
        int            ch;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [3:0]     cfg_res = 4'd9;
    logic           cfg_dir = 1'b0;
    logic           cfg_avg = 1'b0;
    logic [NCH-1:0] trip = '0;
    logic           busy, conv_done, out_valid, out_sof;
    logic [DW-1:0]  out_data;

    int   checks = 0;
    int   fails  = 0;
    exp_t q[$];
    logic prev_valid = 1'b0;
    bit   finished = 0;

    always #4 clk = ~clk;

    ssadc_backend #(.NCH(NCH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_res(cfg_res),
        .cfg_dir(cfg_dir), .cfg_avg(cfg_avg), .trip(trip), .busy(busy),
        .conv_done(conv_done), .out_valid(out_valid), .out_sof(out_sof),
        .out_data(out_data)
    );

    function automatic int gray(int v);
        return v ^ (v >> 1);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each word strobe
    always @(negedge clk) begin
        if (rst_n) begin
            // R9: no back-to-back strobes
            if (prev_valid && out_valid) check("R9 strobe spacing", 1, 0);
            prev_valid <= out_valid;
            if (out_valid) begin
                if (q.size() == 0) begin
                    check("R7/R8 unexpected word", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    // R3 R5 R6: raw Gray word of the selected channel
                    check($sformatf("R3/R5/R6 word ch%0d", e.ch), 32'(out_data), 32'(e.d));
                    // R9: frame sync only with first word
                    check("R9 sof", 32'(out_sof), 32'(e.sof));
                end
            end else if (out_sof) begin
                check("R9 sof without word", 1, 0);
            end
        end
    end

    task automatic run_frame(int res_in, bit dir, bit avg, int seed, bit poke);
        int n;
        int mx;
        int tgt[NCH];
        int nwords;
        int guard;
        n  = (res_in < 9) ? 9 : ((res_in > 14) ? 14 : res_in);   // R2 clamp
        mx = (1 << n) - 1;
        for (int i = 0; i < NCH; i++) begin
            tgt[i] = (i * 37 + seed * 13) % (mx + 1 + mx / 8);
        end
        tgt[2] = 0;
        tgt[4] = mx + 5;
        nwords = avg ? NCH / 2 : NCH;
        for (int k = 0; k < nwords; k++) begin
            exp_t e;
            int ch;
            if (avg) ch = 2 * (dir ? (NCH / 2 - 1 - k) : k);   // R8
            else     ch = dir ? (NCH - 1 - k) : k;             // R7
            e.ch  = ch;
            e.d   = DW'((tgt[ch] <= mx) ? gray(tgt[ch]) : gray(mx));
            e.sof = (k == 0);
            q.push_back(e);
        end
        // R4: idle trip activity has no effect
        trip = '1;
        repeat (3) @(negedge clk);
        trip = '0;
        cfg_res = 4'(res_in);
        cfg_dir = dir;
        cfg_avg = avg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: config changes after start are ignored
        cfg_res = 4'd12;
        cfg_dir = ~dir;
        cfg_avg = ~avg;
        check("R11/R10 busy after start", 32'(busy), 1);
        for (int j = 0; j <= mx; j++) begin
            for (int i = 0; i < NCH; i++) begin
                // R4: channels i%5==0 drop their trip one cycle after capture
                trip[i] = (j >= tgt[i]) && !((i % 5 == 0) && (j == tgt[i] + 1));
            end
            if (j == 0 || j == mx || j == mx - 1)
                check($sformatf("R2 conv_done at count %0d", j), 32'(conv_done), 32'(j == mx));
            @(negedge clk);
        end
        trip = '0;
        if (poke) begin
            repeat (7) @(negedge clk);
            start = 1'b1;   // R10: ignored while busy
            cfg_res = 4'd14;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        check("R8/R7 frame complete", 32'(q.size()), 0);
        q.delete();
        @(negedge clk);
        check("R10 start during readout not queued", 32'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 busy", 32'(busy), 0);
        check("R11 conv_done", 32'(conv_done), 0);
        check("R11 out_valid", 32'(out_valid), 0);
        check("R11 out_sof", 32'(out_sof), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_frame(9, 1'b0, 1'b0, 0, 1'b0);
        run_frame(14, 1'b1, 1'b0, 3, 1'b0);
        run_frame(10, 1'b0, 1'b1, 5, 1'b0);
        run_frame(4, 1'b1, 1'b1, 7, 1'b1);
        run_frame(15, 1'b0, 1'b0, 11, 1'b0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule